// File: doc/BRIEF.md
# Windowed Watchdog Timer

The block is a watchdog that software reaches through a small synchronous register bus. The bus has an address, a write strobe, write data and combinational read data. A 24-bit down-counter runs once the watchdog is enabled and loses one count every clock. If software does not service the watchdog before the counter runs out, the block raises a timeout flag. If reset enable is set, it also sends a one-cycle reset request to the rest of the chip. A second comparator raises a warning interrupt when the counter reaches a programmable value, which gives software early notice.

Software services the watchdog with a strict two-write feed: 0xAA and then 0x55, both written to the feed register. A feed state machine with two states, `FEED_IDLE` and `FEED_ARMED`, checks the pair. Transition *arm* (IDLE to ARMED) happens on a write of 0xAA. Transition *complete* (ARMED to IDLE) happens on a write of 0x55. Transition *break* returns the machine to IDLE on any other feed write, and *stray* keeps it in IDLE on a wrong first write. While the watchdog runs, a completed pair counts as valid only if the counter has already fallen to the window-compare value or below. A pair completed too early, and any broken or stray write, sets the timeout flag instead of reloading the counter.

The mode bits for enable and reset enable do not act when written. They are held pending until the next valid feed, and once either bit is active it cannot be turned off.

Top module: `win_watchdog`

## Requirements
- R1: After reset: mode register reads 0, timeout constant 0xFF, counter 0xFF, warning compare 0, window compare 0xFFFFFF, feed register 0; `warn_irq` and `rst_req` are low.
- R2: Register offsets: mode 0x00, timeout constant 0x04, feed 0x08, counter 0x0C, warning compare 0x14, window compare 0x18. The 24-bit registers read back what was written. The feed register reads 0. Writes to the counter offset are ignored.
- R3: Mode bits are enable (bit 0) and reset enable (bit 1). A mode write only records these bits as pending. They become active, and readable, at the clock edge of the next valid feed. Before then they read as their old value.
- R4: An active enable or reset-enable bit stays 1: a later mode write of 0 followed by a valid feed leaves it at 1.
- R5: A valid feed reloads the counter from the timeout constant. While enabled and not fed, the counter drops by one every clock.
- R6: While enabled, a completed 0xAA/0x55 pair with the counter above the window-compare value is a feed error. It sets the timeout flag and does not reload the counter.
- R7: While enabled, any feed write that breaks the pair is a feed error. This means a first write other than 0xAA, or a write other than 0x55 right after 0xAA, with the whole data word compared. It sets the timeout flag and returns the machine to `FEED_IDLE`. While disabled, a broken write only returns the machine to `FEED_IDLE`.
- R8: While enabled, a counter at 0 that is not being fed expires at the next edge. The timeout flag (mode bit 2) sets and the counter reloads from the timeout constant.
- R9: While enabled, the warning flag (mode bit 3) sets at the edge after the counter equals the warning-compare value. `warn_irq` follows the flag.
- R10: Writing the mode register with bit 2 at 0 clears the timeout flag, and with bit 3 at 0 clears the warning flag, at once and without a feed. A bit written as 1 leaves its flag as it is. A set event in the same cycle wins over a clear.
- R11: `rst_req` is high for exactly one cycle, in the first cycle the timeout flag reads 1 after being 0, and only if reset enable is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 5 | Byte offset of the register accessed |
| wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr`, combinational |
| warn_irq | output | 1 | Warning interrupt (the warning flag) |
| rst_req | output | 1 | One-cycle reset request on a timeout with reset enable active |

## Verification
The feed path is tried with five patterns. These are a clean pair while disabled, a clean pair completed above the window, a clean pair inside the window, a lone 0x55, and 0xAA followed by a near-miss 0x56. Together they separate a reload from a window error and from a sequence error, and show that a disabled watchdog never reports an error. Counter values are read at exact cycles after each feed to tell a reload from plain decrementing. A mode write of zero before a valid feed shows that the enable bits are sticky, and mode reads taken between a mode write and its feed show the pending hold. The run ends with an unfed expiry, which shows the warning flag, the timeout flag, the one-cycle reset request and the reload landing in the expected order.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    // register byte offsets
    localparam int OFF_MODE = 'h00;
    localparam int OFF_TC   = 'h04;
    localparam int OFF_FEED = 'h08;
    localparam int OFF_CNT  = 'h0C;
    localparam int OFF_WARN = 'h14;
    localparam int OFF_WIN  = 'h18;

    // mode register bit positions
    localparam int MB_EN   = 0;
    localparam int MB_RST  = 1;
    localparam int MB_TOF  = 2;
    localparam int MB_WINT = 3;

    // feed pair
    localparam int FEED_KEY1 = 'hAA;
    localparam int FEED_KEY2 = 'h55;

    typedef enum logic {
        FEED_IDLE,
        FEED_ARMED
    } feed_st_e;
endpackage

// File: rtl/wdog_feed_fsm.sv
module wdog_feed_fsm
    import wdog_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              feed_wr,
    input  logic [DATA_W-1:0] feed_data,
    output logic              pair_done,
    output logic              pair_bad
);
    localparam logic [DATA_W-1:0] KEY1 = DATA_W'(FEED_KEY1);
    localparam logic [DATA_W-1:0] KEY2 = DATA_W'(FEED_KEY2);

    feed_st_e st_q, st_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FEED_IDLE;
        else        st_q <= st_d;
    end

    // next state: arm, complete, break, stray
    always_comb begin
        st_d = st_q;
        if (feed_wr) begin
            unique case (st_q)
                FEED_IDLE:  st_d = (feed_data == KEY1) ? FEED_ARMED : FEED_IDLE;
                FEED_ARMED: st_d = FEED_IDLE;
                default:    st_d = FEED_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        pair_done = 1'b0;
        pair_bad  = 1'b0;
        if (feed_wr) begin
            unique case (st_q)
                FEED_IDLE:  pair_bad = (feed_data != KEY1);
                FEED_ARMED: begin
                    pair_done = (feed_data == KEY2);
                    pair_bad  = (feed_data != KEY2);
                end
                default: pair_bad = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int               CNT_W   = 24,
    parameter logic [CNT_W-1:0] CNT_RST = CNT_W'('hFF)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             reload,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ZERO = '0;

    assign expire = run && !reload && (cnt == ZERO);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  cnt <= CNT_RST;
        else if (reload || expire)   cnt <= load_val;
        else if (run)                cnt <= cnt - 1'b1;
    end
endmodule

// File: rtl/win_watchdog.sv
module win_watchdog
    import wdog_pkg::*;
#(
    parameter int               CNT_W  = 24,
    parameter int               DATA_W = 32,
    parameter int               ADDR_W = 5,
    parameter logic [CNT_W-1:0] TC_RST = CNT_W'('hFF)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              warn_irq,
    output logic              rst_req
);
    localparam logic [CNT_W-1:0] WIN_RST = '1;

    logic [CNT_W-1:0] tc_q, warn_q, win_q, cnt;
    logic en_q, rst_en_q, pend_en_q, pend_rst_q, tof_q, wint_q;
    logic pair_done, pair_bad, feed_ok, feed_err, expire;
    logic tof_set, wint_set;
    logic wr_mode, wr_tc, wr_feed, wr_warn, wr_win;

    assign wr_mode = wr_en && (addr == ADDR_W'(OFF_MODE));
    assign wr_tc   = wr_en && (addr == ADDR_W'(OFF_TC));
    assign wr_feed = wr_en && (addr == ADDR_W'(OFF_FEED));
    assign wr_warn = wr_en && (addr == ADDR_W'(OFF_WARN));
    assign wr_win  = wr_en && (addr == ADDR_W'(OFF_WIN));

    wdog_feed_fsm #(.DATA_W(DATA_W)) u_feed (
        .clk       (clk),
        .rst_n     (rst_n),
        .feed_wr   (wr_feed),
        .feed_data (wr_data),
        .pair_done (pair_done),
        .pair_bad  (pair_bad)
    );

    // window judgement: a running watchdog accepts a pair only at or below the window
    assign feed_ok  = pair_done && (!en_q || (cnt <= win_q));
    assign feed_err = en_q && (pair_bad || (pair_done && (cnt > win_q)));

    wdog_counter #(.CNT_W(CNT_W), .CNT_RST(TC_RST)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (en_q),
        .reload   (feed_ok),
        .load_val (tc_q),
        .cnt      (cnt),
        .expire   (expire)
    );

    assign tof_set  = expire || feed_err;
    assign wint_set = en_q && (cnt == warn_q);

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tc_q   <= TC_RST;
            warn_q <= '0;
            win_q  <= WIN_RST;
        end else begin
            if (wr_tc)   tc_q   <= wr_data[CNT_W-1:0];
            if (wr_warn) warn_q <= wr_data[CNT_W-1:0];
            if (wr_win)  win_q  <= wr_data[CNT_W-1:0];
        end
    end

    // mode bits, flags and reset request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q       <= 1'b0;
            rst_en_q   <= 1'b0;
            pend_en_q  <= 1'b0;
            pend_rst_q <= 1'b0;
            tof_q      <= 1'b0;
            wint_q     <= 1'b0;
            rst_req    <= 1'b0;
        end else begin
            if (wr_mode) begin
                pend_en_q  <= wr_data[MB_EN];
                pend_rst_q <= wr_data[MB_RST];
            end
            if (feed_ok) begin
                en_q     <= en_q | pend_en_q;
                rst_en_q <= rst_en_q | pend_rst_q;
            end
            tof_q   <= tof_set  | (tof_q  & ~(wr_mode & ~wr_data[MB_TOF]));
            wint_q  <= wint_set | (wint_q & ~(wr_mode & ~wr_data[MB_WINT]));
            rst_req <= tof_set & ~tof_q & rst_en_q;
        end
    end

    assign warn_irq = wint_q;

    // read mux
    always_comb begin
        case (int'(addr))
            OFF_MODE: rd_data = DATA_W'({wint_q, tof_q, rst_en_q, en_q});
            OFF_TC:   rd_data = DATA_W'(tc_q);
            OFF_CNT:  rd_data = DATA_W'(cnt);
            OFF_WARN: rd_data = DATA_W'(warn_q);
            OFF_WIN:  rd_data = DATA_W'(win_q);
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk #(
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             rst_en,
    input logic             tof,
    input logic             wint,
    input logic             rst_req,
    input logic             feed_ok,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] tc,
    input logic [CNT_W-1:0] warn
);
    // R5
    dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !feed_ok && cnt != '0) |=> (cnt == CNT_W'($past(cnt) - 1'b1)));
    // R5
    feed_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        feed_ok |=> (cnt == $past(tc)));
    // R8
    expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !feed_ok && cnt == '0) |=> (tof && cnt == $past(tc)));
    // R3
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !feed_ok |=> (en == $past(en) && rst_en == $past(rst_en)));
    // R4
    en_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> en);
    // R4
    rst_en_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_en |=> rst_en);
    // R9
    warn_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && cnt == warn) |=> wint);
    // R11
    rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);
    // R11
    rst_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (tof && rst_en && !$past(tof)));
endmodule

bind win_watchdog wdog_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en_q),
    .rst_en  (rst_en_q),
    .tof     (tof_q),
    .wint    (wint_q),
    .rst_req (rst_req),
    .feed_ok (feed_ok),
    .cnt     (cnt),
    .tc      (tc_q),
    .warn    (warn_q)
);

// File: tb/sim_win_watchdog.sv
`timescale 1ns/1ps
module sim_win_watchdog;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        warn_irq, rst_req;

    always #10 clk = ~clk;

    win_watchdog u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .warn_irq(warn_irq), .rst_req(rst_req)
    );

    localparam logic [4:0] A_MODE = 5'h00, A_TC = 5'h04, A_FEED = 5'h08,
                           A_CNT = 5'h0C, A_WARN = 5'h14, A_WIN = 5'h18;

    typedef struct {
        int          kind;   // 0 read data, 1 warn_irq, 2 rst_req
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    logic  smp = 1'b0;
    int    n_chk = 0, n_fail = 0;
    bit    done = 1'b0;

    // monitor: pops expected items and compares
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (smp && q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = q.pop_front();
                case (it.kind)
                    1:       act = {31'b0, warn_irq};
                    2:       act = {31'b0, rst_req};
                    default: act = rd_data;
                endcase
                n_chk++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: got %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    // driver tasks, one slot (clock cycle) each
    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic push_exp(input int k, input logic [31:0] e, input string tag);
        item_t it;
        it.kind = k; it.exp = e; it.tag = tag;
        q.push_back(it);
        smp = 1'b1;
        #3 smp = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        addr = a;
        push_exp(0, e, tag);
    endtask

    task automatic port(input int k, input logic e, input string tag);
        @(negedge clk);
        push_exp(k, {31'b0, e}, tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, got hang expected end");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // slots s0..: state after the previous slot's edge is sampled
        rd(A_MODE, 32'h0, "R1 mode reset");                 // s0
        rd(A_TC, 32'hFF, "R1 tc reset");                    // s1
        rd(A_CNT, 32'hFF, "R1 counter reset");              // s2
        rd(A_WARN, 32'h0, "R1 warn reset");                 // s3
        rd(A_WIN, 32'hFFFFFF, "R1 window reset");           // s4
        rd(A_FEED, 32'h0, "R2 feed reads zero");            // s5
        port(1, 1'b0, "R1 warn_irq low");                   // s6
        port(2, 1'b0, "R1 rst_req low");                    // s7
        wr(A_TC, 32'h20);                                   // s8
        wr(A_WARN, 32'h10);                                 // s9
        wr(A_WIN, 32'h18);                                  // s10
        wr(A_CNT, 32'h777);                                 // s11
        rd(A_CNT, 32'hFF, "R2 counter write ignored");      // s12
        rd(A_TC, 32'h20, "R2 tc readback");                 // s13
        wr(A_MODE, 32'h3);                                  // s14
        rd(A_MODE, 32'h0, "R3 mode pending");               // s15
        wr(A_FEED, 32'hAA);                                 // s16
        rd(A_MODE, 32'h0, "R3 pending mid-pair");           // s17
        wr(A_FEED, 32'h55);                                 // s18 valid (disabled)
        rd(A_CNT, 32'h20, "R5 reload on feed");             // s19
        rd(A_MODE, 32'h3, "R3 mode applied on feed");       // s20
        rd(A_CNT, 32'h1E, "R5 decrement");                  // s21
        wr(A_FEED, 32'hAA);                                 // s22
        wr(A_FEED, 32'h55);                                 // s23 counter 28 > 24
        port(2, 1'b1, "R11 rst_req pulse on window error"); // s24
        port(2, 1'b0, "R11 rst_req one cycle");             // s25
        rd(A_MODE, 32'h7, "R6 early feed sets timeout");    // s26
        rd(A_CNT, 32'd24, "R6 early feed no reload");       // s27
        wr(A_MODE, 32'h3);                                  // s28
        rd(A_MODE, 32'h3, "R10 timeout flag cleared");      // s29
        idle(6);                                            // s30..s35
        port(1, 1'b1, "R9 warn_irq set");                   // s36
        rd(A_MODE, 32'hB, "R9 warning flag in mode");       // s37
        wr(A_FEED, 32'hAA);                                 // s38
        wr(A_FEED, 32'h55);                                 // s39 counter 12 in window
        rd(A_CNT, 32'h20, "R6 feed inside window reloads"); // s40
        rd(A_MODE, 32'hB, "R10 warning flag holds");        // s41
        wr(A_MODE, 32'h3);                                  // s42
        port(1, 1'b0, "R10 warning flag cleared");          // s43
        wr(A_FEED, 32'h55);                                 // s44 stray
        port(2, 1'b1, "R7 rst_req on stray write");         // s45
        rd(A_MODE, 32'h7, "R7 stray write sets timeout");   // s46
        rd(A_CNT, 32'd25, "R7 stray write no reload");      // s47
        wr(A_MODE, 32'h3);                                  // s48
        wr(A_FEED, 32'hAA);                                 // s49
        wr(A_FEED, 32'h56);                                 // s50 break
        rd(A_MODE, 32'h7, "R7 broken pair sets timeout");   // s51
        rd(A_CNT, 32'd20, "R7 broken pair no reload");      // s52
        wr(A_MODE, 32'h0);                                  // s53
        wr(A_FEED, 32'hAA);                                 // s54
        wr(A_FEED, 32'h55);                                 // s55 valid
        rd(A_MODE, 32'h3, "R4 enable bits sticky");         // s56
        rd(A_CNT, 32'd31, "R5 reload then decrement");      // s57
        idle(30);                                           // s58..s87
        rd(A_MODE, 32'hB, "R8 no timeout before expiry");   // s88
        port(2, 1'b1, "R11 rst_req on expiry");             // s89
        rd(A_MODE, 32'hF, "R8 expiry sets timeout");        // s90
        rd(A_CNT, 32'd30, "R8 reload on expiry");           // s91
        port(2, 1'b0, "R11 rst_req back low");              // s92
        idle(2);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule